// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits after a page-table walker and turns the attributes that the walk merged across all levels into a final access decision. Each request carries the merged user, writable and no-execute bits and the leaf entry's dirty, accessed and protection-key fields. It also carries the kind of access, the privilege of the requester, any not-present or reserved-bit result already found by the walker, and the current control flags. One clock later the block returns the read, write and execute grants, a fault flag with a page-fault error code, and a request to write back the leaf entry's accessed and dirty bits.

The grants are built in layers. The basic user and writable rules come first. Supervisor-access prevention (selected per request by an index input) and supervisor-execute prevention are applied on top of them. A per-key register of access-disable and write-disable bit pairs masks the result. Write permission is withheld while the page is still clean, so that the first write comes back through the walker and the dirty bit is set. With paging turned off, every access is granted without any checks.

Top module: `perm_check`

## Requirements
- R1: When `paging_en` is 0, a request returns grants read, write and execute all 1, `fault` 0, `wb_req` 0 and `map_size` 0, whatever the other inputs are.
- R2: With paging on, a request with `walk_rsvd` set faults. Its error code has bit 0 (present/protection) and bit 3 (reserved) set, and all grants are 0.
- R3: With paging on and `walk_rsvd` clear, a request with `walk_np` set faults with error bits 0, 3 and 5 clear.
- R4: A user access (`is_user`=1) to a page with `pg_user`=0 faults as a protection fault (error bit 0 set, bit 5 clear).
- R5: Read is granted unless `sap_idx`=1 and `pg_user`=1.
- R6: Write is granted only when read is granted and either `pg_write`=1, or the access is supervisor with `cr_wp`=0.
- R7: Execute is granted only when the effective no-execute bit (`pg_nx` AND `nx_enable`) is 0 and either the access is user or not (`cr_smep`=1 and `pg_user`=1).
- R8: When `cr_pke`, `long_mode`, `pg_user` are all 1 and `key_reg` is nonzero, key k selects `key_reg[2k+1:2k]`. Bit 2k (access-disable) removes read and write. Otherwise bit 2k+1 (write-disable) removes write, but only if `is_user`=1 or `cr_wp`=1. Execute is never removed by the key.
- R9: If the key mask removes the requested access, the request faults with error bit 5 (key) and bit 0 set.
- R10: Access type encoding: 0 read, 1 write, 2 fetch, 3 treated as read. On any paging fault the error code sets bit 1 for writes and bit 2 for user accesses. It sets bit 4 only for fetches when (`nx_enable` and `ext_addr`) or `cr_smep` is 1. A request faults when the grant selected by its access type is 0.
- R11: A permitted request sets `wb_req` when `pg_accessed`=0 or it is a write to a page with `pg_dirty`=0. `wb_dirty` is 1 exactly for a permitted write.
- R12: A permitted request on a page still clean after the access (`pg_dirty`=0 and not a write) reports write grant 0.
- R13: `rsp_valid` follows `req_valid` by one clock. A faulting response has all grants and `wb_req` at 0. With paging on, `map_size` copies `pg_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| is_user | input | 1 | Requester runs at user privilege |
| sap_idx | input | 1 | Request runs under supervisor-access prevention |
| pg_user | input | 1 | Merged user bit |
| pg_write | input | 1 | Merged writable bit |
| pg_nx | input | 1 | Merged no-execute bit |
| pg_dirty | input | 1 | Leaf dirty bit |
| pg_accessed | input | 1 | Leaf accessed bit |
| pg_key | input | KEY_W | Leaf protection key |
| pg_size | input | 2 | Page size code from the walk |
| walk_np | input | 1 | Walker found a not-present entry |
| walk_rsvd | input | 1 | Walker found a reserved bit set |
| paging_en | input | 1 | Paging enabled |
| cr_wp | input | 1 | Supervisor write-protect |
| cr_smep | input | 1 | Supervisor execute prevention |
| cr_pke | input | 1 | Protection keys enabled |
| long_mode | input | 1 | Long mode active |
| nx_enable | input | 1 | No-execute enabled |
| ext_addr | input | 1 | Extended (64-bit entry) addressing |
| key_reg | input | 2*2**KEY_W | Per-key access/write-disable pairs |
| rsp_valid | output | 1 | Response strobe |
| grant_r | output | 1 | Read granted |
| grant_w | output | 1 | Write granted |
| grant_x | output | 1 | Execute granted |
| fault | output | 1 | Page fault |
| err_code | output | 6 | Fault error code |
| wb_req | output | 1 | Leaf accessed/dirty writeback needed |
| wb_dirty | output | 1 | Writeback also sets dirty |
| map_size | output | 2 | Page size code of the mapping |

## Verification
The bench builds the block with the default `KEY_W` of 4, which gives sixteen keys and a 32-bit key register. Any key index and both bits of every pair can then be reached by random stimulus. About a quarter of the random vectors force the key register to zero, so that both the active and the bypassed key filter are exercised with all other flags random. Directed vectors pin the clean-page write withholding, the key denial of a read, and the fetch error bit under each enabling condition.

// File: rtl/perm_pkg.sv
package perm_pkg;
    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_FX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    localparam int ERR_W   = 6;
    localparam int EB_P    = 0;
    localparam int EB_W    = 1;
    localparam int EB_U    = 2;
    localparam int EB_RSVD = 3;
    localparam int EB_ID   = 4;
    localparam int EB_PK   = 5;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_NP   = 2'd1,
        FC_PROT = 2'd2,
        FC_RSVD = 2'd3
    } fclass_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic             valid;
        logic             fault;
        perm_t            grant;
        logic [ERR_W-1:0] err;
        logic             wb;
        logic             wb_dirty;
        logic [1:0]       size;
    } rsp_t;
endpackage

// File: rtl/perm_base_rules.sv
module perm_base_rules
    import perm_pkg::*;
(
    input  logic  is_user,
    input  logic  sap_idx,
    input  logic  pg_user,
    input  logic  pg_write,
    input  logic  pg_nx,
    input  logic  nx_enable,
    input  logic  cr_wp,
    input  logic  cr_smep,
    output perm_t base,
    output logic  user_viol
);
    logic nx_eff;

    always_comb begin
        nx_eff    = pg_nx & nx_enable;
        user_viol = is_user & ~pg_user;
        base.r    = ~(sap_idx & pg_user);
        base.w    = base.r & (pg_write | (~is_user & ~cr_wp));
        base.x    = ~nx_eff & (is_user | ~(cr_smep & pg_user));
    end
endmodule

// File: rtl/perm_key_filter.sv
module perm_key_filter
    import perm_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int NKEY  = 1 << KEY_W,
    localparam int KR_W  = 2 * NKEY
) (
    input  logic             cr_pke,
    input  logic             long_mode,
    input  logic             pg_user,
    input  logic             is_user,
    input  logic             cr_wp,
    input  logic [KEY_W-1:0] key,
    input  logic [KR_W-1:0]  key_reg,
    output perm_t            mask
);
    logic [NKEY-1:0] ad_vec, wd_vec;
    logic            active, ad, wd;

    for (genvar k = 0; k < NKEY; k++) begin : g_pair
        assign ad_vec[k] = key_reg[2*k];
        assign wd_vec[k] = key_reg[2*k+1];
    end

    always_comb begin
        active = cr_pke & long_mode & pg_user & (|key_reg);
        ad     = ad_vec[key];
        wd     = wd_vec[key];
        mask   = '{r: 1'b1, w: 1'b1, x: 1'b1};
        if (active) begin
            if (ad) begin
                mask.r = 1'b0;
                mask.w = 1'b0;
            end else if (wd && (is_user || cr_wp)) begin
                mask.w = 1'b0;
            end
        end
    end
endmodule

// File: rtl/perm_err_build.sv
module perm_err_build
    import perm_pkg::*;
(
    input  fclass_e          cls,
    input  logic             key_hit,
    input  logic             is_wr,
    input  logic             is_fx,
    input  logic             is_user,
    input  logic             nx_enable,
    input  logic             ext_addr,
    input  logic             cr_smep,
    output logic [ERR_W-1:0] err
);
    always_comb begin
        err = '0;
        if (cls != FC_NONE) begin
            err[EB_P]    = (cls == FC_PROT) || (cls == FC_RSVD);
            err[EB_RSVD] = (cls == FC_RSVD);
            err[EB_PK]   = (cls == FC_PROT) && key_hit;
            err[EB_W]    = is_wr;
            err[EB_U]    = is_user;
            err[EB_ID]   = is_fx && ((nx_enable && ext_addr) || cr_smep);
        end
    end
endmodule

// File: rtl/perm_check.sv
module perm_check
    import perm_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int NKEY  = 1 << KEY_W,
    localparam int KR_W  = 2 * NKEY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       acc_type,
    input  logic             is_user,
    input  logic             sap_idx,
    input  logic             pg_user,
    input  logic             pg_write,
    input  logic             pg_nx,
    input  logic             pg_dirty,
    input  logic             pg_accessed,
    input  logic [KEY_W-1:0] pg_key,
    input  logic [1:0]       pg_size,
    input  logic             walk_np,
    input  logic             walk_rsvd,
    input  logic             paging_en,
    input  logic             cr_wp,
    input  logic             cr_smep,
    input  logic             cr_pke,
    input  logic             long_mode,
    input  logic             nx_enable,
    input  logic             ext_addr,
    input  logic [KR_W-1:0]  key_reg,
    output logic             rsp_valid,
    output logic             grant_r,
    output logic             grant_w,
    output logic             grant_x,
    output logic             fault,
    output logic [ERR_W-1:0] err_code,
    output logic             wb_req,
    output logic             wb_dirty,
    output logic [1:0]       map_size
);
    perm_t            base, kmask, eff;
    logic             user_viol, is_wr, is_fx, want_eff, want_key, key_hit;
    fclass_e          cls;
    logic [ERR_W-1:0] err_w;
    rsp_t             rsp_d, rsp_q;

    perm_base_rules u_base (
        .is_user   (is_user),
        .sap_idx   (sap_idx),
        .pg_user   (pg_user),
        .pg_write  (pg_write),
        .pg_nx     (pg_nx),
        .nx_enable (nx_enable),
        .cr_wp     (cr_wp),
        .cr_smep   (cr_smep),
        .base      (base),
        .user_viol (user_viol)
    );

    perm_key_filter #(.KEY_W(KEY_W)) u_key (
        .cr_pke    (cr_pke),
        .long_mode (long_mode),
        .pg_user   (pg_user),
        .is_user   (is_user),
        .cr_wp     (cr_wp),
        .key       (pg_key),
        .key_reg   (key_reg),
        .mask      (kmask)
    );

    always_comb begin
        is_wr    = (acc_e'(acc_type) == ACC_WR);
        is_fx    = (acc_e'(acc_type) == ACC_FX);
        eff      = base & kmask;
        want_eff = is_wr ? eff.w   : (is_fx ? eff.x   : eff.r);
        want_key = is_wr ? kmask.w : (is_fx ? kmask.x : kmask.r);
        key_hit  = 1'b0;
        if (!paging_en) begin
            cls = FC_NONE;
        end else if (walk_rsvd) begin
            cls = FC_RSVD;
        end else if (walk_np) begin
            cls = FC_NP;
        end else if (user_viol) begin
            cls = FC_PROT;
        end else if (!want_key) begin
            cls     = FC_PROT;
            key_hit = 1'b1;
        end else if (!want_eff) begin
            cls = FC_PROT;
        end else begin
            cls = FC_NONE;
        end
    end

    perm_err_build u_err (
        .cls       (cls),
        .key_hit   (key_hit),
        .is_wr     (is_wr),
        .is_fx     (is_fx),
        .is_user   (is_user),
        .nx_enable (nx_enable),
        .ext_addr  (ext_addr),
        .cr_smep   (cr_smep),
        .err       (err_w)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.err      = err_w;
            rsp_d.fault    = (cls != FC_NONE);
            rsp_d.wb       = 1'b0;
            rsp_d.wb_dirty = 1'b0;
            rsp_d.size     = paging_en ? pg_size : 2'd0;
            if (!paging_en) begin
                rsp_d.grant = '{r: 1'b1, w: 1'b1, x: 1'b1};
            end else if (cls != FC_NONE) begin
                rsp_d.grant = '0;
            end else begin
                rsp_d.grant    = eff;
                rsp_d.wb       = ~pg_accessed | (is_wr & ~pg_dirty);
                rsp_d.wb_dirty = is_wr;
                if (!(pg_dirty || is_wr)) begin
                    rsp_d.grant.w = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign fault     = rsp_q.fault;
    assign grant_r   = rsp_q.grant.r;
    assign grant_w   = rsp_q.grant.w;
    assign grant_x   = rsp_q.grant.x;
    assign err_code  = rsp_q.err;
    assign wb_req    = rsp_q.wb;
    assign wb_dirty  = rsp_q.wb_dirty;
    assign map_size  = rsp_q.size;

    AST_PAGING_OFF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !$past(paging_en) |-> grant_r && grant_w && grant_x && !fault && !wb_req); // R1

    AST_RSVD_SETS_P: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(paging_en && walk_rsvd) |-> fault && err_code[EB_P] && err_code[EB_RSVD]); // R2

    AST_USER_ON_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(paging_en && !walk_rsvd && !walk_np && is_user && !pg_user)
        |-> fault && err_code[EB_P] && !err_code[EB_PK]); // R4

    AST_KEY_NEEDS_P: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && err_code[EB_PK] |-> fault && err_code[EB_P]); // R9

    AST_CLEAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(paging_en && !pg_dirty && acc_type != 2'd1) |-> !grant_w); // R12

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && fault |-> !grant_r && !grant_w && !grant_x && !wb_req); // R13

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> rsp_valid); // R13

    AST_ID_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && err_code[EB_ID] |-> $past(acc_type) == 2'd2); // R10
endmodule

// File: tb/sim_perm_check.sv
module sim_perm_check;
    localparam int KEY_W = 4;
    localparam int NKEY  = 1 << KEY_W;
    localparam int KR_W  = 2 * NKEY;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] acc_type = '0;
    logic is_user = 0, sap_idx = 0, pg_user = 0, pg_write = 0, pg_nx = 0;
    logic pg_dirty = 0, pg_accessed = 0;
    logic [KEY_W-1:0] pg_key = '0;
    logic [1:0] pg_size = '0;
    logic walk_np = 0, walk_rsvd = 0, paging_en = 0, cr_wp = 0, cr_smep = 0;
    logic cr_pke = 0, long_mode = 0, nx_enable = 0, ext_addr = 0;
    logic [KR_W-1:0] key_reg = '0;
    logic rsp_valid, grant_r, grant_w, grant_x, fault, wb_req, wb_dirty;
    logic [5:0] err_code;
    logic [1:0] map_size;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    perm_check #(.KEY_W(KEY_W)) u0 (.*);

    typedef struct packed {
        logic       fault;
        logic [2:0] g;
        logic [5:0] err;
        logic       wb;
        logic       wbd;
        logic [1:0] size;
    } exp_t;

    function automatic exp_t model();
        exp_t e;
        logic wr, fx, r, w, x, kr, kw, act, want, kwant, uv, prot, pk, fl;
        e  = '0;
        wr = (acc_type == 2'd1);
        fx = (acc_type == 2'd2);
        if (!paging_en) begin
            e.g = 3'b111;
            return e;
        end
        e.size = pg_size;
        r  = !(sap_idx && pg_user);
        w  = r && (pg_write || (!is_user && !cr_wp));
        x  = !(pg_nx && nx_enable) && (is_user || !(cr_smep && pg_user));
        kr = 1; kw = 1;
        act = cr_pke && long_mode && pg_user && (key_reg != 0);
        if (act) begin
            if (key_reg[2*pg_key]) begin kr = 0; kw = 0; end
            else if (key_reg[2*pg_key+1] && (is_user || cr_wp)) kw = 0;
        end
        r = r && kr; w = w && kw;
        want  = wr ? w : (fx ? x : r);
        kwant = wr ? kw : (fx ? 1'b1 : kr);
        uv = is_user && !pg_user;
        prot = 0; pk = 0; fl = 1;
        if (walk_rsvd) begin e.err[3] = 1; prot = 1; end
        else if (walk_np) prot = 0;
        else if (uv) prot = 1;
        else if (!kwant) begin prot = 1; pk = 1; end
        else if (!want) prot = 1;
        else fl = 0;
        if (fl) begin
            e.fault  = 1;
            e.err[0] = prot;
            e.err[5] = pk;
            e.err[1] = wr;
            e.err[2] = is_user;
            e.err[4] = fx && ((nx_enable && ext_addr) || cr_smep);
        end else begin
            e.g   = {r, (pg_dirty || wr) ? w : 1'b0, x};
            e.wb  = !pg_accessed || (wr && !pg_dirty);
            e.wbd = wr;
        end
        return e;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply_and_check();
        exp_t e;
        e = model();
        req_valid = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R13 valid", {31'd0, rsp_valid}, 32'd1);
        chk(fault == e.fault, "R2 R3 R4 R9 R10 fault", {31'd0, fault}, {31'd0, e.fault});
        chk({grant_r, grant_w, grant_x} == e.g, "R1 R5 R6 R7 R8 R12 R13 grants",
            {29'd0, grant_r, grant_w, grant_x}, {29'd0, e.g});
        chk(err_code == e.err, "R2 R3 R9 R10 errcode", {26'd0, err_code}, {26'd0, e.err});
        chk({wb_req, wb_dirty} == {e.wb, e.wbd}, "R11 writeback",
            {30'd0, wb_req, wb_dirty}, {30'd0, e.wb, e.wbd});
        chk(map_size == e.size, "R1 R13 size", {30'd0, map_size}, {30'd0, e.size});
    endtask

    task automatic clear_inputs();
        acc_type = 0; is_user = 0; sap_idx = 0; pg_user = 0; pg_write = 0; pg_nx = 0;
        pg_dirty = 0; pg_accessed = 0; pg_key = 0; pg_size = 0; walk_np = 0; walk_rsvd = 0;
        paging_en = 1; cr_wp = 0; cr_smep = 0; cr_pke = 0; long_mode = 0; nx_enable = 0;
        ext_addr = 0; key_reg = '0;
    endtask

    task automatic randomize_inputs();
        acc_type    = 2'($urandom_range(0, 3));
        is_user     = 1'($urandom);
        sap_idx     = ($urandom_range(0, 3) == 0);
        pg_user     = 1'($urandom);
        pg_write    = 1'($urandom);
        pg_nx       = 1'($urandom);
        pg_dirty    = 1'($urandom);
        pg_accessed = 1'($urandom);
        pg_key      = KEY_W'($urandom);
        pg_size     = 2'($urandom);
        walk_np     = ($urandom_range(0, 19) == 0);
        walk_rsvd   = ($urandom_range(0, 19) == 0);
        paging_en   = ($urandom_range(0, 9) != 0);
        cr_wp       = 1'($urandom);
        cr_smep     = 1'($urandom);
        cr_pke      = ($urandom_range(0, 3) != 0);
        long_mode   = ($urandom_range(0, 3) != 0);
        nx_enable   = 1'($urandom);
        ext_addr    = 1'($urandom);
        key_reg     = ($urandom_range(0, 3) == 0) ? '0 : KR_W'($urandom);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 0 && fault == 0 && {grant_r, grant_w, grant_x} == 0,
            "R13 reset", {29'd0, rsp_valid, fault, 1'b0}, 32'd0);

        // R1 paging off with hostile inputs
        clear_inputs(); paging_en = 0; walk_rsvd = 1; is_user = 1; acc_type = 1; pg_size = 3;
        apply_and_check();
        // R12 clean page read: write withheld, R11 accessed writeback
        clear_inputs(); pg_write = 1; acc_type = 0;
        apply_and_check();
        // R11 write to clean page sets dirty
        clear_inputs(); pg_write = 1; pg_accessed = 1; acc_type = 1;
        apply_and_check();
        // R8 R9 key access-disable denies a read
        clear_inputs(); pg_user = 1; is_user = 1; pg_dirty = 1; pg_accessed = 1;
        cr_pke = 1; long_mode = 1; pg_key = 4'd5; key_reg = KR_W'(1) << 10;
        apply_and_check();
        // R8 write-disable ignored for supervisor with wp off
        clear_inputs(); pg_user = 1; pg_write = 1; pg_dirty = 1; pg_accessed = 1; acc_type = 1;
        cr_pke = 1; long_mode = 1; pg_key = 4'd3; key_reg = KR_W'(1) << 7;
        apply_and_check();
        // R10 fetch error bit via smep, R7
        clear_inputs(); pg_user = 1; acc_type = 2; cr_smep = 1;
        apply_and_check();
        // R10 fetch bit via nx with extended addressing
        clear_inputs(); pg_nx = 1; nx_enable = 1; ext_addr = 1; acc_type = 2; pg_dirty = 1;
        apply_and_check();
        // R3 not present
        clear_inputs(); walk_np = 1; acc_type = 1; is_user = 1;
        apply_and_check();
        // R5 access prevention on user page
        clear_inputs(); sap_idx = 1; pg_user = 1; pg_dirty = 1; pg_accessed = 1;
        apply_and_check();
        // R13 valid drops one cycle after req_valid
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R13 idle", {31'd0, rsp_valid}, 32'd0);

        for (int i = 0; i < 4000; i++) begin
            randomize_inputs();
            apply_and_check();
        end
        req_valid = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule